// File: doc/BRIEF.md
# Multi-level priority interrupt controller

This block gathers interrupt requests from a fixed set of processor-core event sources and from programmable external and peripheral sources, and picks a single winner to hand to the core. Arbitration has two tiers. The highest priority level among the eligible requests wins first. Inside that level, the lowest vector number wins. The controller presents the winner as an interrupt strobe with its vector number, its level, and the address the core fetches from. That address is a relocatable base plus two words per vector.

Vector numbers are fixed by source position. Vectors 0 and 1 are reserved for reset entry and are never arbitrated. Vectors 2–5 and 11–13 are core sources with hard-wired levels. Vectors 6–10 are debug event sources with a programmable level. Vectors 14 and 15 are external request lines. Vectors 16 and up are peripheral sources.

The core sources (vectors 2–13) are event-type: a request is latched until the core acknowledges that vector. The sources from vector 14 up are level-type and stay pending only while their input is high. The core supplies its current priority mask and an acknowledge.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A pending eligible request at a higher level always wins over any request at a lower level, whatever the vector numbers.
- R2: Among eligible requests at the same level, the lowest vector number wins.
- R3: `addr_o` equals `vbase_i` plus two times `vec_o`, using the base value present in the cycle the winner was captured.
- R4: Request inputs 0 and 1 never cause a request to be presented.
- R5: The levels of the core sources are fixed and ignore their configuration bits:
  - vectors 2, 3, 4 and 5 are at level 3;
  - vector 11 is at level 2;
  - vector 12 is at level 1;
  - vector 13 is at level 0.
- R6: The level of programmable source v is read from `lvl_cfg_i[2v+1:2v]` and clamped to that source's allowed range:
  - vectors 6–10 allow levels 1 to 3, so a written 0 becomes 1;
  - vectors 14–15 allow levels 0 to 2, so a written 3 becomes 2;
  - vectors 16 and up take the written value as is.
- R7: `en_cfg_i[v]` = 0 blocks programmable source v. Fixed core sources ignore their enable bit.
- R8: A request is presented only when its level is greater than or equal to `mask_i`. A level-3 request is always presented.
- R9: A request on vectors 2–13 is latched on any cycle its input is high. The latch is cleared when the core acknowledges that vector, unless the input is still high in the acknowledge cycle.
- R10: Vectors 14 and up are pending exactly while their input is high, and are not affected by acknowledge.
- R11: Output timing:
  - the winner is registered and appears on the outputs one clock after the inputs change;
  - while `irq_o` is high and not acknowledged, all outputs hold;
  - in the clock after an acknowledge, `irq_o` is low.
- R12: During and just after reset, `irq_o`, `vec_o`, `lvl_o` and `addr_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_VEC | Request line per vector number |
| lvl_cfg_i | input | 2*NUM_VEC | Two-bit level field per source |
| en_cfg_i | input | NUM_VEC | Enable per programmable source |
| vbase_i | input | AW | Vector table base address |
| mask_i | input | 2 | Core's current priority mask |
| ack_i | input | 1 | Core accepts the presented vector |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | VW | Winning vector number |
| lvl_o | output | 2 | Winning level |
| addr_o | output | AW | Vector fetch address |

## Verification
The hardest case to reach from the ports is an event-type request that arrives and goes away while another vector is held unacknowledged on the outputs. The latched request is invisible until the held vector is acknowledged, and it must then appear even though its input has long been low. The bench creates this case as follows:
1. It holds a level-type request so that its vector is presented and frozen.
2. It pulses a level-3 event source for a single cycle and releases it.
3. It acknowledges the held vector.
4. It checks that the idle cycle is followed by the latched vector.
5. It acknowledges that vector and checks that the latch is gone.

// File: rtl/pic_pkg.sv
package pic_pkg;

   typedef enum logic [2:0] {
      SRC_NONE,
      SRC_FIXED,
      SRC_DBG,
      SRC_EXT,
      SRC_PERIPH
   } src_kind_e;

   // Source class by vector position; vector numbers are part of behaviour.
   function automatic src_kind_e kind_of(input int v);
      if (v < 2)        return SRC_NONE;
      else if (v <= 5)  return SRC_FIXED;
      else if (v <= 10) return SRC_DBG;
      else if (v <= 13) return SRC_FIXED;
      else if (v <= 15) return SRC_EXT;
      else              return SRC_PERIPH;
   endfunction

   // Event-type (latched) sources are the core ones.
   function automatic bit is_event(input int v);
      return (v >= 2) && (v <= 13);
   endfunction

   // Effective level after applying fixed values and range clamping.
   function automatic logic [1:0] resolve_lvl(input int v, input logic [1:0] cfg);
      logic [1:0] r;
      case (kind_of(v))
         SRC_FIXED:  r = (v <= 5) ? 2'd3 : 2'(13 - v);
         SRC_DBG:    r = (cfg == 2'd0) ? 2'd1 : cfg;
         SRC_EXT:    r = (cfg == 2'd3) ? 2'd2 : cfg;
         SRC_PERIPH: r = cfg;
         default:    r = 2'd0;
      endcase
      return r;
   endfunction

   // Whether a source takes part in arbitration.
   function automatic logic resolve_en(input int v, input logic en);
      logic r;
      case (kind_of(v))
         SRC_NONE:  r = 1'b0;
         SRC_FIXED: r = 1'b1;
         default:   r = en;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pic_src_map.sv
module pic_src_map
   import pic_pkg::*;
#(
   parameter int NUM_VEC = 24
) (
   input  logic [2*NUM_VEC-1:0]     lvl_cfg_i,
   input  logic [NUM_VEC-1:0]       en_cfg_i,
   output logic [NUM_VEC-1:0][1:0]  eff_lvl_o,
   output logic [NUM_VEC-1:0]       src_en_o
);

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_src
      always_comb begin
         eff_lvl_o[v] = resolve_lvl(v, lvl_cfg_i[2*v +: 2]);
         src_en_o[v]  = resolve_en(v, en_cfg_i[v]);
      end
   end

endmodule

// File: rtl/pic_pend.sv
module pic_pend
   import pic_pkg::*;
#(
   parameter int NUM_VEC = 24,
   parameter int VW      = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] req_i,
   input  logic               take_i,
   input  logic [VW-1:0]      take_vec_i,
   output logic [NUM_VEC-1:0] pend_o
);

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_pend
      if (is_event(v)) begin : g_event
         logic held_q;
         logic clr;
         assign clr = take_i && (take_vec_i == VW'(v));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          held_q <= 1'b0;
            else if (req_i[v])   held_q <= 1'b1;
            else if (clr)        held_q <= 1'b0;
         end
         assign pend_o[v] = held_q | req_i[v];
      end else begin : g_level
         assign pend_o[v] = req_i[v];
      end
   end

endmodule

// File: rtl/pic_arb.sv
module pic_arb #(
   parameter int NUM_VEC = 24,
   parameter int VW      = 5
) (
   input  logic [NUM_VEC-1:0]       pend_i,
   input  logic [NUM_VEC-1:0]       src_en_i,
   input  logic [NUM_VEC-1:0][1:0]  eff_lvl_i,
   input  logic [1:0]               mask_i,
   output logic                     any_o,
   output logic [VW-1:0]            win_vec_o,
   output logic [1:0]               win_lvl_o
);

   localparam int NUM_LVL = 4;

   logic [NUM_VEC-1:0] elig;

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_elig
      assign elig[v] = pend_i[v] && src_en_i[v] &&
                       ((eff_lvl_i[v] >= mask_i) || (eff_lvl_i[v] == 2'd3));
   end

   always_comb begin
      logic          hit;
      logic [VW-1:0] lv;
      any_o     = 1'b0;
      win_vec_o = '0;
      win_lvl_o = '0;
      for (int l = 0; l < NUM_LVL; l++) begin
         hit = 1'b0;
         lv  = '0;
         for (int v = NUM_VEC - 1; v >= 0; v--) begin
            if (elig[v] && (eff_lvl_i[v] == 2'(l))) begin
               hit = 1'b1;
               lv  = VW'(v);
            end
         end
         if (hit) begin
            any_o     = 1'b1;
            win_vec_o = lv;
            win_lvl_o = 2'(l);
         end
      end
   end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
   parameter int NUM_VEC = 24,
   parameter int VW      = $clog2(NUM_VEC),
   parameter int AW      = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_VEC-1:0]    req_i,
   input  logic [2*NUM_VEC-1:0]  lvl_cfg_i,
   input  logic [NUM_VEC-1:0]    en_cfg_i,
   input  logic [AW-1:0]         vbase_i,
   input  logic [1:0]            mask_i,
   input  logic                  ack_i,
   output logic                  irq_o,
   output logic [VW-1:0]         vec_o,
   output logic [1:0]            lvl_o,
   output logic [AW-1:0]         addr_o
);

   if (NUM_VEC < 17) begin : g_chk_vec
      $error("prio_irq_ctrl: NUM_VEC must cover the fixed sources and at least one peripheral");
   end
   if ((1 << VW) < NUM_VEC) begin : g_chk_vw
      $error("prio_irq_ctrl: VW too narrow for NUM_VEC");
   end
   if (AW <= VW + 1) begin : g_chk_aw
      $error("prio_irq_ctrl: AW must exceed VW+1");
   end

   logic [NUM_VEC-1:0][1:0] eff_lvl;
   logic [NUM_VEC-1:0]      src_en;
   logic [NUM_VEC-1:0]      pend;
   logic                    any;
   logic [VW-1:0]           win_vec;
   logic [1:0]              win_lvl;
   logic                    take;

   assign take = irq_o && ack_i;

   pic_src_map #(.NUM_VEC(NUM_VEC)) u_map (
      .lvl_cfg_i (lvl_cfg_i),
      .en_cfg_i  (en_cfg_i),
      .eff_lvl_o (eff_lvl),
      .src_en_o  (src_en)
   );

   pic_pend #(.NUM_VEC(NUM_VEC), .VW(VW)) u_pend (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req_i),
      .take_i     (take),
      .take_vec_i (vec_o),
      .pend_o     (pend)
   );

   pic_arb #(.NUM_VEC(NUM_VEC), .VW(VW)) u_arb (
      .pend_i    (pend),
      .src_en_i  (src_en),
      .eff_lvl_i (eff_lvl),
      .mask_i    (mask_i),
      .any_o     (any),
      .win_vec_o (win_vec),
      .win_lvl_o (win_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_o  <= 1'b0;
         vec_o  <= '0;
         lvl_o  <= '0;
         addr_o <= '0;
      end else if (take) begin
         irq_o <= 1'b0;
      end else if (!irq_o) begin
         irq_o  <= any;
         vec_o  <= win_vec;
         lvl_o  <= win_lvl;
         addr_o <= vbase_i + AW'({win_vec, 1'b0});
      end
   end

endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
   parameter int VW = 5,
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    mask_i,
   input logic          ack_i,
   input logic [AW-1:0] vbase_i,
   input logic          irq_o,
   input logic [VW-1:0] vec_o,
   input logic [1:0]    lvl_o,
   input logic [AW-1:0] addr_o
);

   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !ack_i) |=> (irq_o && $stable(vec_o) && $stable(lvl_o) && $stable(addr_o)));

   p_ack_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && ack_i) |=> !irq_o);

   p_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> (addr_o == $past(vbase_i) + AW'({vec_o, 1'b0})));

   p_no_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (vec_o >= VW'(2)));

   p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> ((lvl_o >= $past(mask_i)) || (lvl_o == 2'd3)));

   p_fixed_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && (vec_o >= VW'(2)) && (vec_o <= VW'(5))) |-> (lvl_o == 2'd3));

endmodule

bind prio_irq_ctrl pic_checker #(.VW(VW), .AW(AW)) u_pic_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .mask_i  (mask_i),
   .ack_i   (ack_i),
   .vbase_i (vbase_i),
   .irq_o   (irq_o),
   .vec_o   (vec_o),
   .lvl_o   (lvl_o),
   .addr_o  (addr_o)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;

   localparam int NV = 24;
   localparam int VW = 5;
   localparam int AW = 16;

   typedef struct packed {
      logic [NV-1:0] req;
      logic [1:0]    mask;
      logic          irq;
      logic [VW-1:0] vec;
      logic [1:0]    lvl;
   } row_t;

   localparam int NROW = 17;
   localparam row_t TBL [0:NROW-1] = '{
      '{24'h010000, 2'd0, 1'b1, 5'd16, 2'd3},  // R6 periph cfg 3
      '{24'h010004, 2'd0, 1'b1, 5'd2,  2'd3},  // R2 same level, lower vec; R7 fixed ignores enable
      '{24'h018000, 2'd0, 1'b1, 5'd16, 2'd3},  // R1 level beats lower vector number
      '{24'h000080, 2'd0, 1'b1, 5'd7,  2'd1},  // R6 debug 0 clamps to 1
      '{24'h004000, 2'd0, 1'b1, 5'd14, 2'd2},  // R6 ext 3 clamps to 2
      '{24'h040000, 2'd0, 1'b0, 5'd0,  2'd0},  // R7 disabled source
      '{24'h060000, 2'd0, 1'b1, 5'd17, 2'd0},  // R7 disabled loses to enabled
      '{24'h008000, 2'd2, 1'b0, 5'd0,  2'd0},  // R8 below mask
      '{24'h004000, 2'd2, 1'b1, 5'd14, 2'd2},  // R8 equal to mask
      '{24'h010000, 2'd3, 1'b1, 5'd16, 2'd3},  // R8 level 3 at mask 3
      '{24'h000800, 2'd0, 1'b1, 5'd11, 2'd2},  // R5 vec 11
      '{24'h001000, 2'd0, 1'b1, 5'd12, 2'd1},  // R5 vec 12
      '{24'h002000, 2'd0, 1'b1, 5'd13, 2'd0},  // R5 vec 13
      '{24'h008040, 2'd0, 1'b1, 5'd6,  2'd2},  // R1 debug cfg 2 over ext level 1
      '{24'h120000, 2'd0, 1'b1, 5'd17, 2'd0},  // R2 both level 0
      '{24'h000003, 2'd0, 1'b0, 5'd0,  2'd0},  // R4 reserved inputs
      '{24'h000020, 2'd3, 1'b1, 5'd5,  2'd3}   // R5 fixed level 3 despite cfg 0
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NV-1:0]     req = '0;
   logic [2*NV-1:0]   lvl_cfg;
   logic [NV-1:0]     en_cfg;
   logic [AW-1:0]     vbase = 16'h1000;
   logic [1:0]        mask = 2'd0;
   logic              ack = 1'b0;
   logic              irq;
   logic [VW-1:0]     vec;
   logic [1:0]        lvl;
   logic [AW-1:0]     addr;

   int n_run  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   prio_irq_ctrl #(.NUM_VEC(NV), .VW(VW), .AW(AW)) u_prio_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .req_i(req), .lvl_cfg_i(lvl_cfg),
      .en_cfg_i(en_cfg), .vbase_i(vbase), .mask_i(mask), .ack_i(ack),
      .irq_o(irq), .vec_o(vec), .lvl_o(lvl), .addr_o(addr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic nclk(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic chk_win(input string tag, input logic [VW-1:0] ev, input logic [1:0] el);
      chk({tag, " irq"}, 32'(irq), 32'd1);
      chk({tag, " vec"}, 32'(vec), 32'(ev));
      chk({tag, " lvl"}, 32'(lvl), 32'(el));
      chk({tag, " addr R3"}, 32'(addr), 32'(vbase + 16'(2 * ev)));
   endtask

   initial begin
      lvl_cfg = '0;
      lvl_cfg[2*6 +: 2]  = 2'd2;
      lvl_cfg[2*7 +: 2]  = 2'd0;
      lvl_cfg[2*14 +: 2] = 2'd3;
      lvl_cfg[2*15 +: 2] = 2'd1;
      lvl_cfg[2*16 +: 2] = 2'd3;
      lvl_cfg[2*18 +: 2] = 2'd2;
      en_cfg = '1;
      en_cfg[18] = 1'b0;
      en_cfg[2]  = 1'b0;
   end

   initial begin : watchdog
      #400000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      nclk(3);
      chk("R12 reset irq", 32'(irq), 32'd0);
      chk("R12 reset vec", 32'(vec), 32'd0);
      chk("R12 reset addr", 32'(addr), 32'd0);
      rst_n = 1'b1;
      nclk(2);
      chk("R12 idle after reset", 32'(irq), 32'd0);

      for (int r = 0; r < NROW; r++) begin
         req  = TBL[r].req;
         mask = TBL[r].mask;
         nclk(1);
         if (TBL[r].irq) begin
            chk_win($sformatf("row %0d", r), TBL[r].vec, TBL[r].lvl);
            ack = 1'b1;
         end else begin
            chk($sformatf("row %0d none", r), 32'(irq), 32'd0);
         end
         req = '0;
         nclk(1);
         ack = 1'b0;
         mask = 2'd0;
         nclk(2);
      end

      // R9/R11: event latched while another vector is held
      req = 24'h008000;
      nclk(1);
      chk_win("R11 present 15", 5'd15, 2'd1);
      req = 24'h008010;
      nclk(1);
      req = 24'h008000;
      nclk(1);
      chk("R11 hold vec", 32'(vec), 32'd15);
      ack = 1'b1; req = '0;
      nclk(1);
      ack = 1'b0;
      chk("R11 idle after ack", 32'(irq), 32'd0);
      nclk(1);
      chk_win("R9 latched vec 4", 5'd4, 2'd3);
      ack = 1'b1;
      nclk(1);
      ack = 1'b0;
      nclk(2);
      chk("R9 latch cleared", 32'(irq), 32'd0);

      // R10: level source returns after ack while held
      req = 24'h008000;
      nclk(1);
      ack = 1'b1;
      nclk(1);
      ack = 1'b0;
      chk("R11 idle cycle", 32'(irq), 32'd0);
      nclk(1);
      chk_win("R10 level re-presented", 5'd15, 2'd1);
      ack = 1'b1; req = '0;
      nclk(1);
      ack = 1'b0;
      nclk(2);
      chk("R10 gone with input", 32'(irq), 32'd0);

      // R3: relocated base
      vbase = 16'h0200;
      req = 24'h010000;
      nclk(1);
      chk("R3 relocated addr", 32'(addr), 32'h0220);
      ack = 1'b1; req = '0;
      nclk(1);
      ack = 1'b0;
      nclk(2);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule